// File: doc/BRIEF.md
# Clock Distributor Channel Programming Sequencer

This block brings up a fourteen-output clock distribution device over a shared serial shifter and then stays available for run-time adjustment of the sync-pulse phase of two data converters. A single `start` pulse launches the whole bring-up. First the device identity is read back from three registers. Then the block issues a soft reset and the global setup. Last, it loads every output channel's configuration registers, using enable flags and divider values fixed by parameters.

The block does not shift bits itself. It hands one frame at a time to the serial shifter through a valid/ready request port. Each request carries a left-aligned 32-bit word, a length code (bit count minus one), a flag that keeps chip-select asserted after the frame, and a flag that selects a half-duplex (receive) frame. The shifter returns a received byte with a one-cycle `ret_valid` strobe.

When bring-up has finished, a phase request names a converter and a 9-bit phase. The low four bits are the fine (analog) step, limited to 16 steps. The upper five bits are the coarse (digital) step. The block writes the two fields into that converter's pair of delay registers.

Top module: `clkdist_prog`

## Requirements
- R1: After reset, `busy`, `init_done`, `id_fail`, `idx_err` and `frm_valid` are all 0.
- R2: A write frame has length code 23 and both `frm_hold_cs` and `frm_half_duplex` at 0. Its data word carries 0 in bit 31, the 15-bit register address in bits [30:16], the data byte in bits [15:8], and zero in bits [7:0].
- R3: A register read is two frames. The first is a command frame with length code 15, `frm_hold_cs`=1, half-duplex 0 and data {1'b1, address[14:0], 16'h0000}. The second is a frame with length code 7, `frm_hold_cs`=0, `frm_half_duplex`=1 and data 0. The byte is taken from `ret_byte` in the cycle `ret_valid` is high.
- R4: Bring-up begins by reading registers 0x78, 0x79 and 0x7A in that order and packing the bytes most significant first. If the result differs from 0xF17904, `id_fail` goes to 1, the block returns to idle, no write frame is issued and `init_done` stays 0.
- R5: After a good identity, the block writes 0x01 and then 0x00 to register 0x00, followed by 0x3B to register 0x04.
- R6: The block then programs channels 0 to 13 in ascending order. Channel n uses base address 0xC8 + 0x0A·n. Each channel gets writes at offsets +0, +1, +2, +3, +4, +7 and +8, in that order.
- R7: Offset +0 receives 0x91 for an enabled even channel, 0x11 for an enabled odd channel and 0x10 for a disabled channel. Offset +1 receives divider bits [7:0] and offset +2 receives divider bits [10:8]. Offsets +3 and +4 receive 0x00. Offset +7 receives 0x00 on even channels and 0x01 on odd channels. Offset +8 receives 0x08.
- R8: After the last channel write, `init_done` is 1 and `busy` is 0. A `start` pulse while `busy` is 1 is ignored.
- R9: A phase request is accepted only when `init_done` is 1 and `busy` is 0, and is ignored otherwise. For converter 0 the block writes phase[3:0] to 0xD5 and then phase[8:4] to 0xD6. For converter 1 it writes to 0xE9 and then 0xEA.
- R10: An accepted request whose converter index is 2 or 3 sets `idx_err` and issues no frame. The next accepted request with a valid index clears `idx_err`.
- R11: While `frm_valid` is 1 and `frm_ready` is 0, the frame request stays asserted and its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch bring-up (ignored while busy) |
| phase_req | input | 1 | Request a sync-phase update |
| phase_sel | input | 2 | Converter index for the update |
| phase_val | input | 9 | Phase: [3:0] fine step, [8:4] coarse step |
| frm_valid | output | 1 | Frame request pending |
| frm_ready | input | 1 | Shifter accepts the pending frame |
| frm_data | output | 32 | Left-aligned frame word |
| frm_len | output | 5 | Frame bit count minus one |
| frm_hold_cs | output | 1 | Keep chip-select asserted after this frame |
| frm_half_duplex | output | 1 | Frame receives instead of transmitting |
| ret_valid | input | 1 | Received byte strobe |
| ret_byte | input | 8 | Received byte |
| busy | output | 1 | Sequence in progress |
| init_done | output | 1 | Bring-up finished successfully |
| id_fail | output | 1 | Identity mismatch seen |
| idx_err | output | 1 | Last accepted phase request had a bad index |

## Verification
Any `start` or `phase_req` is captured at the clock edge where it is high. `busy` and `idx_err` change at that same edge. The first frame request appears one edge later, and each further frame takes one load edge plus its handshake edge. The bench samples outputs on the falling edge, so every registered change is already visible. A monitor records each frame at the falling edge before the handshake edge. After a read's half-duplex frame, the monitor returns the byte three cycles later. Frame lists are compared against independently built expectations only after `busy` has dropped, and error-flag checks wait a few cycles after the request edge.

// File: rtl/clkdist_pkg.sv
package clkdist_pkg;

    localparam int ADDR_W = 15;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;
    localparam int LEN_W  = 5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_IDCMD,
        S_IDDAT,
        S_IDWAIT,
        S_IDCHK,
        S_GLOB,
        S_CHAN,
        S_PHASE
    } state_e;

    typedef enum logic [1:0] {
        FK_WRITE,
        FK_RDCMD,
        FK_RDDATA
    } fkind_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [LEN_W-1:0]  len;
        logic              hold;
        logic              hd;
    } frame_t;

endpackage

// File: rtl/clkdist_frame_fmt.sv
module clkdist_frame_fmt
    import clkdist_pkg::*;
(
    input  fkind_e                  kind,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTE_W-1:0]       wdata,
    output frame_t                  frame
);
    localparam logic [LEN_W-1:0] LEN_WR  = LEN_W'(ADDR_W + 1 + BYTE_W - 1);
    localparam logic [LEN_W-1:0] LEN_CMD = LEN_W'(ADDR_W + 1 - 1);
    localparam logic [LEN_W-1:0] LEN_RD  = LEN_W'(BYTE_W - 1);

    always_comb begin
        frame = '0;
        case (kind)
            FK_WRITE: begin
                frame.data = {1'b0, addr, wdata, {(WORD_W-ADDR_W-1-BYTE_W){1'b0}}};
                frame.len  = LEN_WR;
            end
            FK_RDCMD: begin
                frame.data = {1'b1, addr, {(WORD_W-ADDR_W-1){1'b0}}};
                frame.len  = LEN_CMD;
                frame.hold = 1'b1;
            end
            default: begin
                frame.len  = LEN_RD;
                frame.hd   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/clkdist_chan_rom.sv
module clkdist_chan_rom
    import clkdist_pkg::*;
#(
    parameter int NUM_CH    = 14,
    parameter int DIV_W     = 11,
    parameter int CH_W      = 4,
    parameter int CH_BASE   = 'hC8,
    parameter int CH_STRIDE = 'h0A,
    parameter logic [NUM_CH-1:0]       CH_EN  = '0,
    parameter logic [NUM_CH*DIV_W-1:0] CH_DIV = '0
) (
    input  logic [CH_W-1:0]   ch,
    input  logic [2:0]        step,
    output logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] value
);
    localparam logic [BYTE_W-1:0] CFG_CLK = 8'h91;
    localparam logic [BYTE_W-1:0] CFG_SYN = 8'h11;
    localparam logic [BYTE_W-1:0] CFG_OFF = 8'h10;
    localparam logic [BYTE_W-1:0] DRV_VAL = 8'h08;

    logic [DIV_W-1:0]  div;
    logic [ADDR_W-1:0] off;
    logic              odd;
    logic              en;

    always_comb begin
        div = CH_DIV[int'(ch)*DIV_W +: DIV_W];
        odd = ch[0];
        en  = CH_EN[ch];
        case (step)
            3'd5:    off = ADDR_W'(7);
            3'd6:    off = ADDR_W'(8);
            default: off = ADDR_W'(step);
        endcase
        addr = ADDR_W'(CH_BASE) + ADDR_W'(CH_STRIDE) * ADDR_W'(ch) + off;
        case (step)
            3'd0:    value = !en ? CFG_OFF : (odd ? CFG_SYN : CFG_CLK);
            3'd1:    value = div[BYTE_W-1:0];
            3'd2:    value = BYTE_W'(div[DIV_W-1:BYTE_W]);
            3'd5:    value = {{(BYTE_W-1){1'b0}}, odd};
            3'd6:    value = DRV_VAL;
            default: value = '0;
        endcase
    end
endmodule

// File: rtl/clkdist_prog.sv
module clkdist_prog
    import clkdist_pkg::*;
#(
    parameter int NUM_CH    = 14,
    parameter int DIV_W     = 11,
    parameter int CH_BASE   = 'hC8,
    parameter int CH_STRIDE = 'h0A,
    parameter logic [NUM_CH-1:0]       CH_EN  = 14'h07CF,
    parameter logic [NUM_CH*DIV_W-1:0] CH_DIV =
        {11'd0, 11'd0, 11'd0, 11'd8, 11'd8, 11'd8, 11'd128,
         11'd8, 11'd0, 11'd0, 11'd128, 11'd2, 11'd128, 11'd2},
    parameter int ID_BASE   = 'h78,
    parameter logic [23:0] ID_EXPECT = 24'hF17904,
    parameter logic [7:0]  GRP_EN    = 8'h3B,
    parameter int PH_ADDR0  = 'hD5,
    parameter int PH_ADDR1  = 'hE9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        phase_req,
    input  logic [1:0]  phase_sel,
    input  logic [8:0]  phase_val,
    output logic        frm_valid,
    input  logic        frm_ready,
    output logic [31:0] frm_data,
    output logic [4:0]  frm_len,
    output logic        frm_hold_cs,
    output logic        frm_half_duplex,
    input  logic        ret_valid,
    input  logic [7:0]  ret_byte,
    output logic        busy,
    output logic        init_done,
    output logic        id_fail,
    output logic        idx_err
);
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int ID_BYTES = 3;
    localparam int STEPS    = 7;

    typedef struct packed {
        state_e            state;
        logic [1:0]        idx;
        logic [CH_W-1:0]   ch;
        logic [2:0]        step;
        logic [23:0]       id;
        logic              vld;
        frame_t            frame;
        logic              done;
        logic              idfail;
        logic              ierr;
        logic              psel;
        logic [8:0]        phase;
    } regs_t;

    regs_t r_d, r_q;

    fkind_e            f_kind;
    logic [ADDR_W-1:0] f_addr;
    logic [BYTE_W-1:0] f_wdata;
    frame_t            f_new;
    logic [ADDR_W-1:0] ch_addr;
    logic [BYTE_W-1:0] ch_value;
    logic              hs;
    logic              sending;

    clkdist_chan_rom #(
        .NUM_CH(NUM_CH), .DIV_W(DIV_W), .CH_W(CH_W),
        .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE),
        .CH_EN(CH_EN), .CH_DIV(CH_DIV)
    ) u_rom (
        .ch(r_q.ch), .step(r_q.step), .addr(ch_addr), .value(ch_value)
    );

    clkdist_frame_fmt u_fmt (
        .kind(f_kind), .addr(f_addr), .wdata(f_wdata), .frame(f_new)
    );

    // frame source selection
    always_comb begin
        f_kind  = FK_WRITE;
        f_addr  = '0;
        f_wdata = '0;
        case (r_q.state)
            S_IDCMD: begin
                f_kind = FK_RDCMD;
                f_addr = ADDR_W'(ID_BASE) + ADDR_W'(r_q.idx);
            end
            S_IDDAT: f_kind = FK_RDDATA;
            S_GLOB: begin
                case (r_q.idx)
                    2'd0:    f_wdata = 8'h01;
                    2'd1:    f_wdata = 8'h00;
                    default: begin
                        f_addr  = ADDR_W'(4);
                        f_wdata = GRP_EN;
                    end
                endcase
            end
            S_CHAN: begin
                f_addr  = ch_addr;
                f_wdata = ch_value;
            end
            S_PHASE: begin
                f_addr = (r_q.psel ? ADDR_W'(PH_ADDR1) : ADDR_W'(PH_ADDR0))
                         + ADDR_W'(r_q.step[0]);
                f_wdata = r_q.step[0] ? {3'b0, r_q.phase[8:4]} : {4'b0, r_q.phase[3:0]};
            end
            default: ;
        endcase
    end

    // next-state computation
    always_comb begin
        r_d     = r_q;
        hs      = r_q.vld && frm_ready;
        sending = (r_q.state == S_IDCMD) || (r_q.state == S_IDDAT) ||
                  (r_q.state == S_GLOB)  || (r_q.state == S_CHAN)  ||
                  (r_q.state == S_PHASE);
        if (sending && !r_q.vld) begin
            r_d.vld   = 1'b1;
            r_d.frame = f_new;
        end
        if (hs) r_d.vld = 1'b0;

        case (r_q.state)
            S_IDLE: begin
                if (start) begin
                    r_d.state  = S_IDCMD;
                    r_d.idx    = '0;
                    r_d.id     = '0;
                    r_d.done   = 1'b0;
                    r_d.idfail = 1'b0;
                    r_d.ierr   = 1'b0;
                end else if (phase_req && r_q.done) begin
                    if (phase_sel > 2'd1) begin
                        r_d.ierr = 1'b1;
                    end else begin
                        r_d.ierr  = 1'b0;
                        r_d.psel  = phase_sel[0];
                        r_d.phase = phase_val;
                        r_d.step  = '0;
                        r_d.state = S_PHASE;
                    end
                end
            end
            S_IDCMD: if (hs) r_d.state = S_IDDAT;
            S_IDDAT: if (hs) r_d.state = S_IDWAIT;
            S_IDWAIT: begin
                if (ret_valid) begin
                    r_d.id = {r_q.id[15:0], ret_byte};
                    if (r_q.idx == 2'(ID_BYTES - 1)) begin
                        r_d.state = S_IDCHK;
                    end else begin
                        r_d.idx   = r_q.idx + 2'd1;
                        r_d.state = S_IDCMD;
                    end
                end
            end
            S_IDCHK: begin
                if (r_q.id == ID_EXPECT) begin
                    r_d.state = S_GLOB;
                    r_d.idx   = '0;
                end else begin
                    r_d.idfail = 1'b1;
                    r_d.state  = S_IDLE;
                end
            end
            S_GLOB: begin
                if (hs) begin
                    if (r_q.idx == 2'd2) begin
                        r_d.state = S_CHAN;
                        r_d.ch    = '0;
                        r_d.step  = '0;
                    end else begin
                        r_d.idx = r_q.idx + 2'd1;
                    end
                end
            end
            S_CHAN: begin
                if (hs) begin
                    if (r_q.step == 3'(STEPS - 1)) begin
                        r_d.step = '0;
                        if (r_q.ch == CH_W'(NUM_CH - 1)) begin
                            r_d.state = S_IDLE;
                            r_d.done  = 1'b1;
                        end else begin
                            r_d.ch = r_q.ch + 1'b1;
                        end
                    end else begin
                        r_d.step = r_q.step + 3'd1;
                    end
                end
            end
            S_PHASE: begin
                if (hs) begin
                    if (r_q.step[0]) r_d.state = S_IDLE;
                    else             r_d.step  = 3'd1;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign frm_valid       = r_q.vld;
    assign frm_data        = r_q.frame.data;
    assign frm_len         = r_q.frame.len;
    assign frm_hold_cs     = r_q.frame.hold;
    assign frm_half_duplex = r_q.frame.hd;
    assign busy            = (r_q.state != S_IDLE);
    assign init_done       = r_q.done;
    assign id_fail         = r_q.idfail;
    assign idx_err         = r_q.ierr;

    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_data) &&
                                        $stable(frm_len) && $stable(frm_hold_cs) &&
                                        $stable(frm_half_duplex)));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !frm_valid);

    p_done_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !id_fail);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> !busy);

    p_bad_index_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && init_done && !start && phase_req && phase_sel > 2'd1)
        |=> (idx_err && !busy));

endmodule

// File: tb/tb_clkdist_prog.sv
module tb_clkdist_prog;
    localparam int NCH = 14;
    localparam logic [NCH-1:0] TB_EN = 14'h07CF;
    localparam logic [NCH*11-1:0] TB_DIV =
        {11'd0, 11'd0, 11'd0, 11'd8, 11'd8, 11'd8, 11'd128,
         11'd8, 11'h7FF, 11'd0, 11'd128, 11'd2, 11'h4C3, 11'd2};
    localparam int NINIT = 6 + 3 + NCH * 7;

    // {sel[1:0], phase[8:0], a0[14:0], d0[7:0], a1[14:0], d1[7:0], err}
    localparam int NV = 6;
    localparam logic [57:0] VEC [NV] = '{
        {2'd0, 9'h1FF, 15'hD5, 8'h0F, 15'hD6, 8'h1F, 1'b0},
        {2'd1, 9'h0A5, 15'hE9, 8'h05, 15'hEA, 8'h0A, 1'b0},
        {2'd2, 9'h123, 15'h00, 8'h00, 15'h00, 8'h00, 1'b1},
        {2'd0, 9'h100, 15'hD5, 8'h00, 15'hD6, 8'h10, 1'b0},
        {2'd3, 9'h0FF, 15'h00, 8'h00, 15'h00, 8'h00, 1'b1},
        {2'd1, 9'h13C, 15'hE9, 8'h0C, 15'hEA, 8'h13, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, phase_req = 1'b0;
    logic [1:0] phase_sel = '0;
    logic [8:0] phase_val = '0;
    logic frm_valid, frm_ready = 1'b1;
    logic [31:0] frm_data;
    logic [4:0] frm_len;
    logic frm_hold_cs, frm_half_duplex;
    logic ret_valid = 1'b0;
    logic [7:0] ret_byte = '0;
    logic busy, init_done, id_fail, idx_err;

    int checks = 0, errors = 0, cyc = 0;
    logic stall = 1'b0;
    logic [7:0] id_tab [3] = '{8'hF1, 8'h79, 8'h04};

    logic [31:0] lg_data [256];
    logic [4:0]  lg_len  [256];
    logic        lg_hold [256];
    logic        lg_hd   [256];
    int nlog = 0, nrd = 0, pend = 0;
    logic [7:0] pend_byte = '0;

    clkdist_prog #(.NUM_CH(NCH), .CH_EN(TB_EN), .CH_DIV(TB_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .phase_req(phase_req),
        .phase_sel(phase_sel), .phase_val(phase_val), .frm_valid(frm_valid),
        .frm_ready(frm_ready), .frm_data(frm_data), .frm_len(frm_len),
        .frm_hold_cs(frm_hold_cs), .frm_half_duplex(frm_half_duplex),
        .ret_valid(ret_valid), .ret_byte(ret_byte), .busy(busy),
        .init_done(init_done), .id_fail(id_fail), .idx_err(idx_err)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
                summary();
            end
        end
    end

    // shifter model: log handshakes before the edge, drive after it
    initial begin
        forever begin
            @(negedge clk);
            if (frm_valid && frm_ready) begin
                lg_data[nlog] = frm_data; lg_len[nlog] = frm_len;
                lg_hold[nlog] = frm_hold_cs; lg_hd[nlog] = frm_half_duplex;
                nlog++;
                if (frm_half_duplex) begin
                    pend = 3;
                    pend_byte = id_tab[nrd % 3];
                    nrd++;
                end
            end
            @(posedge clk);
            #1;
            frm_ready = stall ? cyc[0] : 1'b1;
            ret_valid = (pend == 1);
            ret_byte  = (pend == 1) ? pend_byte : 8'h00;
            if (pend > 0) pend--;
        end
    end

    function automatic logic [31:0] wr_word(input logic [14:0] a, input logic [7:0] d);
        return {1'b0, a, d, 8'h00};
    endfunction

    task automatic chk(input string req, input logic ok, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_write(input string req, input int i, input logic [14:0] a,
                             input logic [7:0] d);
        logic [31:0] e;
        e = wr_word(a, d);
        chk(req, i < nlog && lg_data[i] == e && lg_len[i] == 5'd23 &&
                 !lg_hold[i] && !lg_hd[i],
            {lg_data[i], 25'(lg_len[i]), lg_hold[i], lg_hd[i]}, {e, 25'd23, 2'b00});
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic pulse_phase(input logic [1:0] s, input logic [8:0] p);
        @(posedge clk); #1 phase_req = 1'b1; phase_sel = s; phase_val = p;
        @(posedge clk); #1 phase_req = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [14:0] off_of(input int st);
        return (st == 5) ? 15'd7 : (st == 6) ? 15'd8 : 15'(st);
    endfunction

    function automatic logic [7:0] val_of(input int c, input int st);
        logic [10:0] dv;
        dv = TB_DIV[c*11 +: 11];
        case (st)
            0: return !TB_EN[c] ? 8'h10 : ((c % 2) ? 8'h11 : 8'h91);
            1: return dv[7:0];
            2: return {5'b0, dv[10:8]};
            5: return (c % 2) ? 8'h01 : 8'h00;
            6: return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 reset outputs", !busy && !init_done && !id_fail && !idx_err && !frm_valid,
            {59'd0, busy, init_done, id_fail, idx_err, frm_valid}, 64'd0);
        #1 rst_n = 1'b1;

        // R9: request before bring-up is ignored
        nlog = 0;
        pulse_phase(2'd0, 9'h055);
        repeat (10) @(negedge clk);
        chk("R9 request before init ignored", nlog == 0 && !busy && !idx_err,
            64'(nlog), 64'd0);

        // full bring-up with a second start while busy (R8)
        nlog = 0; nrd = 0;
        pulse_start();
        repeat (40) @(negedge clk);
        pulse_start();
        wait_idle();
        chk("R8 done after bring-up", init_done && !busy && !id_fail,
            {61'd0, init_done, busy, id_fail}, {61'd0, 3'b100});
        chk("R8 frame count", nlog == NINIT, 64'(nlog), 64'(NINIT));
        for (int k = 0; k < 3; k++) begin
            chk("R3 R4 read command frame",
                lg_data[2*k] == {1'b1, 15'(8'h78 + k), 16'h0} && lg_len[2*k] == 5'd15 &&
                lg_hold[2*k] && !lg_hd[2*k],
                {lg_data[2*k], 27'(lg_len[2*k]), lg_hold[2*k], lg_hd[2*k]},
                {1'b1, 15'(8'h78 + k), 16'h0, 27'd15, 2'b10});
            chk("R3 half-duplex frame",
                lg_data[2*k+1] == 32'h0 && lg_len[2*k+1] == 5'd7 &&
                !lg_hold[2*k+1] && lg_hd[2*k+1],
                {lg_data[2*k+1], 27'(lg_len[2*k+1]), lg_hold[2*k+1], lg_hd[2*k+1]},
                {32'h0, 27'd7, 2'b01});
        end
        chk_write("R5 R2 soft reset set", 6, 15'h0, 8'h01);
        chk_write("R5 soft reset clear", 7, 15'h0, 8'h00);
        chk_write("R5 group enable", 8, 15'h4, 8'h3B);
        for (int c = 0; c < NCH; c++) begin
            for (int st = 0; st < 7; st++) begin
                chk_write("R6 R7 channel register", 9 + c*7 + st,
                          15'(15'hC8 + 15'h0A * 15'(c)) + off_of(st), val_of(c, st));
            end
        end

        // phase-update vectors (R9, R10)
        for (int v = 0; v < NV; v++) begin
            logic [57:0] e;
            e = VEC[v];
            nlog = 0;
            pulse_phase(e[57:56], e[55:47]);
            wait_idle();
            if (e[0]) begin
                chk("R10 bad index flagged, no frame", idx_err && nlog == 0,
                    {31'd0, idx_err, 32'(nlog)}, {31'd0, 1'b1, 32'd0});
            end else begin
                chk("R10 flag clear on valid index", !idx_err && nlog == 2,
                    {31'd0, idx_err, 32'(nlog)}, {32'd0, 32'd2});
                chk_write("R9 fine phase write", 0, e[46:32], e[31:24]);
                chk_write("R9 coarse phase write", 1, e[23:9], e[8:1]);
            end
        end

        // R11: frames survive a stalling shifter
        stall = 1'b1;
        nlog = 0;
        pulse_phase(2'd1, 9'h1E7);
        wait_idle();
        chk("R11 count under stall", nlog == 2, 64'(nlog), 64'd2);
        chk_write("R11 fine write under stall", 0, 15'hE9, 8'h07);
        chk_write("R11 coarse write under stall", 1, 15'hEA, 8'h1E);
        stall = 1'b0;

        // bad identity (R4)
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk); #1 rst_n = 1'b1;
        id_tab[1] = 8'h78;
        nlog = 0; nrd = 0;
        pulse_start();
        wait_idle();
        chk("R4 identity mismatch flagged", id_fail && !init_done,
            {62'd0, id_fail, init_done}, {62'd0, 2'b10});
        chk("R4 no write after mismatch", nlog == 6, 64'(nlog), 64'd6);
        nlog = 0;
        pulse_phase(2'd0, 9'h011);
        repeat (10) @(negedge clk);
        chk("R9 request ignored without init", nlog == 0 && !busy, 64'(nlog), 64'd0);

        summary();
    end
endmodule